// File: doc/BRIEF.md
# Glitchless clock divider change sequencer

This block steps a clock generator from one setting (reference divide M, feedback multiply N, post-divide code) to another without letting the output clock glitch. A request carries the present and wanted settings plus two conditions: whether a slow N slide is allowed, and whether the loop is running. The block then issues register-style write strobes to the post-divide field and to an output linear divider that halves the clock. It waits a fixed settle time after engaging that divider, and it finishes by handing N to an external slide engine. Lock, bypass programming and sliding live outside and are seen only as request/done handshakes.

A post-divide change is taken as clean only when the old and new codes have a set bit in common. When they have none, the block first writes an interim code that shares a bit with both. When M is unchanged and sliding is allowed on a running loop, the change is made in place (the fast path). Any other change asks the outside for a program-and-lock under bypass. Whenever code 1 is at either end, the output divider is set to 1:2 beforehand and put back to 1:1 afterwards.

States, in sequence order: S_IDLE, S_START, S_HALF_W1, S_HALF_W2, S_HALF_RD, S_SETTLE_IN, S_FAST_MID, S_FAST_TGT, S_BYP_RUN, S_BYP_TGT, S_SETTLE_OUT, S_FULL_W1, S_FULL_W2, S_FULL_RD, S_SLIDE_RUN. The transitions are:
- S_IDLE moves to S_START on a legal request.
- S_START moves to S_HALF_W1 when 1:2 is needed, and otherwise dispatches.
- S_HALF_W1, S_HALF_W2, S_HALF_RD and S_SETTLE_IN follow one another. S_SETTLE_IN dispatches when the timer ends.
- Dispatch goes to S_FAST_MID (fast path, interim code needed), to S_FAST_TGT (fast path, no interim) or to S_BYP_RUN (all other cases).
- S_FAST_MID moves to S_FAST_TGT. S_BYP_RUN moves to S_BYP_TGT on bypass done.
- Both target states go to S_SETTLE_OUT when the divider reads back as 1:2, and to S_SLIDE_RUN otherwise.
- S_SETTLE_OUT moves to S_FULL_W1 when the timer ends. S_FULL_W1, S_FULL_W2, S_FULL_RD and S_SLIDE_RUN follow one another.
- S_SLIDE_RUN returns to S_IDLE on slide done.

Top module: `pll_step_seq`

## Requirements
- R1: After reset, busy, err, pl_wr, ldiv_wr, ldiv_rd, bypass_req and slide_req are all low.
- R2: On the fast path, if (cur_pl AND new_pl) is zero, the block writes an interim code on pl_wr_code. The interim code is the smaller of (cur_pl OR lowest set bit of new_pl) and (new_pl OR lowest set bit of cur_pl). The target code follows in the next cycle. Otherwise only the target is written. Examples: 1→2 writes 3 then 2, 4→3 writes 5 then 3, and 3→2 writes only 2.
- R3: Each post-divide code written shares a set bit with the code in force before it. The code in force is cur_pl at the start, and new_pl once bypass programming is done.
- R4: When cur_pl or new_pl is 1, the output divider is written to 1:2 (ldiv_half=1) before the first pl_wr or bypass_req. Every pl_wr whose previous or written code is 1 happens while the divider is at 1:2.
- R5: Every output-divider update is ldiv_wr high for exactly two consecutive cycles with the same ldiv_half, followed by one cycle of ldiv_rd.
- R6: With SETTLE_CYCLES = CLK_MHZ·SETTLE_US, the first pl_wr or bypass_req comes SETTLE_CYCLES+1 cycles after the read-back that engaged 1:2. The first restoring ldiv_wr comes SETTLE_CYCLES+1 cycles after the target pl_wr.
- R7: The fast path (no bypass_req) is taken exactly when allow_slide=1, pll_enabled=1 and new_m equals cur_m.
- R8: On the bypass path, bypass_req stays high until bypass_done, with bypass_m=new_m. bypass_n is ceil(new_m·VCO_MIN_MHZ/FIN_MHZ) when allow_slide=1, and new_n otherwise. Exactly one write of new_pl follows.
- R9: After the target write, the divider is restored to 1:1 (ldiv_half=0) only when ldiv_state_half=1. Otherwise no ldiv_wr occurs.
- R10: The sequence ends with slide_req held high and slide_n=new_n until slide_done.
- R11: busy is high from the cycle after a request is accepted until the cycle after slide_done. A req_valid seen while busy has no effect.
- R12: A request with cur_pl=0 or new_pl=0 raises err for exactly one cycle, produces no strobe and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Change request, taken while idle |
| cur_m | input | M_W | Present reference divide |
| new_m | input | M_W | Wanted reference divide |
| new_n | input | N_W | Wanted feedback multiply |
| cur_pl | input | PL_W | Present post-divide code |
| new_pl | input | PL_W | Wanted post-divide code |
| allow_slide | input | 1 | A slow N slide is permitted |
| pll_enabled | input | 1 | The loop is running |
| ldiv_state_half | input | 1 | Read-back of the output divider: 1 means 1:2 |
| bypass_done | input | 1 | Program-and-lock under bypass finished |
| slide_done | input | 1 | N slide finished |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle pulse for an illegal code |
| pl_wr | output | 1 | Post-divide field write strobe |
| pl_wr_code | output | PL_W | Code written with pl_wr |
| ldiv_wr | output | 1 | Output divider write strobe |
| ldiv_half | output | 1 | Value written: 1 for 1:2, 0 for 1:1 |
| ldiv_rd | output | 1 | Output divider read-back strobe |
| bypass_req | output | 1 | Request program-and-lock under bypass |
| bypass_m | output | M_W | M for bypass programming |
| bypass_n | output | N_W | N for bypass programming |
| slide_req | output | 1 | Request a slide to slide_n |
| slide_n | output | N_W | Target N for the slide |

## Verification
The bench builds the block with its default parameters: 4-bit codes, CLK_MHZ=200 and SETTLE_US=2, which gives 400-cycle settle windows, and VCO_MIN_MHZ=1300 with FIN_MHZ=12. With those values M=3 gives an exact bypass N of 325, while M=1 and M=4 round up to 109 and 434, so both sides of the ceiling are exercised. The 4-bit codes reach the 1↔2, 4→3 and 2→5 interim cases. The settle windows are short enough that both waits of a 1:2 sequence can be timed to the exact cycle.

// File: rtl/pll_step_pkg.sv
package pll_step_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_HALF_W1,
        S_HALF_W2,
        S_HALF_RD,
        S_SETTLE_IN,
        S_FAST_MID,
        S_FAST_TGT,
        S_BYP_RUN,
        S_BYP_TGT,
        S_SETTLE_OUT,
        S_FULL_W1,
        S_FULL_W2,
        S_FULL_RD,
        S_SLIDE_RUN
    } seq_state_e;

endpackage

// File: rtl/pldiv_interim.sv
// Picks a stepping-stone code when two codes have no set bit in common.
// Output 0 means no interim step is needed.
module pldiv_interim #(
    parameter int PL_W = 4
) (
    input  logic [PL_W-1:0] old_code,
    input  logic [PL_W-1:0] new_code,
    output logic [PL_W-1:0] mid_code
);
    logic [PL_W-1:0] low_old, low_new, cand_a, cand_b;

    always_comb begin
        low_old = old_code & (~old_code + PL_W'(1));
        low_new = new_code & (~new_code + PL_W'(1));
        cand_a  = old_code | low_new;
        cand_b  = new_code | low_old;
        if ((old_code & new_code) != '0) begin
            mid_code = '0;
        end else begin
            mid_code = (cand_a < cand_b) ? cand_a : cand_b;
        end
    end
endmodule

// File: rtl/vco_min_n.sv
// Feedback value that puts the VCO at its floor: ceil(m * VCO_MIN / FIN).
module vco_min_n #(
    parameter int M_W         = 8,
    parameter int N_W         = 10,
    parameter int VCO_MIN_MHZ = 1300,
    parameter int FIN_MHZ     = 12
) (
    input  logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_floor
);
    logic [31:0] prod, quot;

    assign prod    = 32'(m_val) * 32'(VCO_MIN_MHZ);
    assign quot    = (prod + 32'(FIN_MHZ - 1)) / 32'(FIN_MHZ);
    assign n_floor = N_W'(quot);
endmodule

// File: rtl/settle_timer.sv
// Counts while run is high; done marks the last cycle of the window.
module settle_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pll_step_seq.sv
module pll_step_seq
    import pll_step_pkg::*;
#(
    parameter int PL_W        = 4,
    parameter int M_W         = 8,
    parameter int N_W         = 10,
    parameter int CLK_MHZ     = 200,
    parameter int SETTLE_US   = 2,
    parameter int VCO_MIN_MHZ = 1300,
    parameter int FIN_MHZ     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [M_W-1:0]  cur_m,
    input  logic [M_W-1:0]  new_m,
    input  logic [N_W-1:0]  new_n,
    input  logic [PL_W-1:0] cur_pl,
    input  logic [PL_W-1:0] new_pl,
    input  logic            allow_slide,
    input  logic            pll_enabled,
    input  logic            ldiv_state_half,
    input  logic            bypass_done,
    input  logic            slide_done,
    output logic            busy,
    output logic            err,
    output logic            pl_wr,
    output logic [PL_W-1:0] pl_wr_code,
    output logic            ldiv_wr,
    output logic            ldiv_half,
    output logic            ldiv_rd,
    output logic            bypass_req,
    output logic [M_W-1:0]  bypass_m,
    output logic [N_W-1:0]  bypass_n,
    output logic            slide_req,
    output logic [N_W-1:0]  slide_n
);
    localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;

    seq_state_e state, nxt, dispatch;

    logic [PL_W-1:0] r_cur_pl, r_new_pl, mid_code;
    logic [M_W-1:0]  r_m;
    logic [N_W-1:0]  r_n, n_floor;
    logic            r_allow, r_fast, r_half, err_q;
    logic            accept, illegal, tmr_run, tmr_done;

    assign accept  = (state == S_IDLE) && req_valid;
    assign illegal = (cur_pl == '0) || (new_pl == '0);
    assign tmr_run = (state == S_SETTLE_IN) || (state == S_SETTLE_OUT);

    pldiv_interim #(.PL_W(PL_W)) i_interim (
        .old_code (r_cur_pl),
        .new_code (r_new_pl),
        .mid_code (mid_code)
    );

    vco_min_n #(
        .M_W(M_W), .N_W(N_W), .VCO_MIN_MHZ(VCO_MIN_MHZ), .FIN_MHZ(FIN_MHZ)
    ) i_nfloor (
        .m_val   (r_m),
        .n_floor (n_floor)
    );

    settle_timer #(.CYCLES(SETTLE_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_cur_pl <= '0;
            r_new_pl <= '0;
            r_m      <= '0;
            r_n      <= '0;
            r_allow  <= 1'b0;
            r_fast   <= 1'b0;
            r_half   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= accept && illegal;
            if (accept && !illegal) begin
                r_cur_pl <= cur_pl;
                r_new_pl <= new_pl;
                r_m      <= new_m;
                r_n      <= new_n;
                r_allow  <= allow_slide;
                r_fast   <= allow_slide && pll_enabled && (new_m == cur_m);
                r_half   <= (cur_pl < PL_W'(2)) || (new_pl < PL_W'(2));
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        if (!r_fast) begin
            dispatch = S_BYP_RUN;
        end else if (mid_code != '0) begin
            dispatch = S_FAST_MID;
        end else begin
            dispatch = S_FAST_TGT;
        end

        nxt = state;
        unique case (state)
            S_IDLE:       if (req_valid && !illegal) nxt = S_START;
            S_START:      nxt = r_half ? S_HALF_W1 : dispatch;
            S_HALF_W1:    nxt = S_HALF_W2;
            S_HALF_W2:    nxt = S_HALF_RD;
            S_HALF_RD:    nxt = S_SETTLE_IN;
            S_SETTLE_IN:  if (tmr_done) nxt = dispatch;
            S_FAST_MID:   nxt = S_FAST_TGT;
            S_FAST_TGT,
            S_BYP_TGT:    nxt = ldiv_state_half ? S_SETTLE_OUT : S_SLIDE_RUN;
            S_BYP_RUN:    if (bypass_done) nxt = S_BYP_TGT;
            S_SETTLE_OUT: if (tmr_done) nxt = S_FULL_W1;
            S_FULL_W1:    nxt = S_FULL_W2;
            S_FULL_W2:    nxt = S_FULL_RD;
            S_FULL_RD:    nxt = S_SLIDE_RUN;
            S_SLIDE_RUN:  if (slide_done) nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = (state != S_IDLE);
        err        = err_q;
        pl_wr      = (state == S_FAST_MID) || (state == S_FAST_TGT) ||
                     (state == S_BYP_TGT);
        pl_wr_code = (state == S_FAST_MID) ? mid_code : r_new_pl;
        ldiv_wr    = (state == S_HALF_W1) || (state == S_HALF_W2) ||
                     (state == S_FULL_W1) || (state == S_FULL_W2);
        ldiv_half  = (state == S_HALF_W1) || (state == S_HALF_W2);
        ldiv_rd    = (state == S_HALF_RD) || (state == S_FULL_RD);
        bypass_req = (state == S_BYP_RUN);
        bypass_m   = r_m;
        bypass_n   = r_allow ? n_floor : r_n;
        slide_req  = (state == S_SLIDE_RUN);
        slide_n    = r_n;
    end
endmodule

// File: rtl/pll_step_seq_chk.sv
module pll_step_seq_chk #(
    parameter int PL_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            err,
    input logic            pl_wr,
    input logic [PL_W-1:0] pl_wr_code,
    input logic            ldiv_wr,
    input logic            ldiv_half,
    input logic            ldiv_rd,
    input logic            bypass_req,
    input logic            bypass_done,
    input logic            slide_req,
    input logic            slide_done
);
    AST_LDIV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldiv_wr) |=> ldiv_wr && $stable(ldiv_half)); // R5
    AST_LDIV_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ldiv_wr && $past(ldiv_wr) |=> ldiv_rd && !ldiv_wr); // R5
    AST_PL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pl_wr |-> pl_wr_code != '0); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(pl_wr || ldiv_wr || ldiv_rd || bypass_req || slide_req)); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R12
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R12
    AST_BYP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_req && !bypass_done |=> bypass_req); // R8
    AST_SLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        slide_req && !slide_done |=> slide_req); // R10
    AST_SLIDE_END: assert property (@(posedge clk) disable iff (!rst_n)
        slide_req && slide_done |=> !busy); // R11
endmodule

bind pll_step_seq pll_step_seq_chk #(.PL_W(PL_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .err         (err),
    .pl_wr       (pl_wr),
    .pl_wr_code  (pl_wr_code),
    .ldiv_wr     (ldiv_wr),
    .ldiv_half   (ldiv_half),
    .ldiv_rd     (ldiv_rd),
    .bypass_req  (bypass_req),
    .bypass_done (bypass_done),
    .slide_req   (slide_req),
    .slide_done  (slide_done)
);

// File: tb/test_pll_step_seq.sv
`timescale 1ns/1ps
module test_pll_step_seq;
    localparam int SETTLE = 200 * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] cur_m = '0, new_m = '0;
    logic [9:0] new_n = '0;
    logic [3:0] cur_pl = '0, new_pl = '0;
    logic allow_slide = 1'b0, pll_enabled = 1'b0;
    logic ldiv_reg = 1'b0;
    logic bypass_done = 1'b0, slide_done = 1'b0;

    logic busy, err, pl_wr, ldiv_wr, ldiv_half, ldiv_rd, bypass_req, slide_req;
    logic [3:0] pl_wr_code;
    logic [7:0] bypass_m;
    logic [9:0] bypass_n, slide_n;

    always #2.5 clk = ~clk;

    pll_step_seq #(
        .PL_W(4), .M_W(8), .N_W(10), .CLK_MHZ(200), .SETTLE_US(2),
        .VCO_MIN_MHZ(1300), .FIN_MHZ(12)
    ) i_pll_step_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cur_m(cur_m), .new_m(new_m), .new_n(new_n),
        .cur_pl(cur_pl), .new_pl(new_pl),
        .allow_slide(allow_slide), .pll_enabled(pll_enabled),
        .ldiv_state_half(ldiv_reg), .bypass_done(bypass_done),
        .slide_done(slide_done),
        .busy(busy), .err(err), .pl_wr(pl_wr), .pl_wr_code(pl_wr_code),
        .ldiv_wr(ldiv_wr), .ldiv_half(ldiv_half), .ldiv_rd(ldiv_rd),
        .bypass_req(bypass_req), .bypass_m(bypass_m), .bypass_n(bypass_n),
        .slide_req(slide_req), .slide_n(slide_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // observation log
    int cyc = 0, pl_cnt, ldiv_cnt, rd_cnt, glitch_bad, one_bad, ld_bad;
    int half_gap, rest_gap, err_cyc, busy_cyc, byp_seen, slide_seen;
    int t_rd, t_pl, lw_run;
    logic [3:0] pl_log [8];
    logic       ldiv_log [8];
    logic [9:0] byp_n_seen, slide_n_seen;
    logic [7:0] byp_m_seen;
    logic [3:0] prev_code, exp_new;
    logic lw_v0, lw_v1, byp_prev;
    bit arm_h, arm_r;
    int bc = 0, sc = 0;

    // external handshake responders
    always @(negedge clk) begin
        if (bypass_req && !bypass_done) begin
            bc <= bc + 1;
            if (bc == 4) bypass_done <= 1'b1;
        end else begin
            bc <= 0;
            bypass_done <= 1'b0;
        end
        if (slide_req && !slide_done) begin
            sc <= sc + 1;
            if (sc == 3) slide_done <= 1'b1;
        end else begin
            sc <= 0;
            slide_done <= 1'b0;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (busy) busy_cyc++;
            if (err) err_cyc++;
            if (bypass_done) prev_code = exp_new;
            if (pl_wr) begin
                if (pl_cnt < 8) pl_log[pl_cnt] = pl_wr_code;
                pl_cnt++;
                if ((prev_code & pl_wr_code) == 4'd0) glitch_bad++;
                if ((prev_code == 4'd1 || pl_wr_code == 4'd1) && !ldiv_reg) one_bad++;
                prev_code = pl_wr_code;
                if (arm_h) begin half_gap = cyc - t_rd; arm_h = 0; end
                t_pl = cyc;
                arm_r = 1;
            end
            if (bypass_req && !byp_prev) begin
                byp_seen++;
                byp_n_seen = bypass_n;
                byp_m_seen = bypass_m;
                if (arm_h) begin half_gap = cyc - t_rd; arm_h = 0; end
            end
            byp_prev = bypass_req;
            if (slide_req) slide_n_seen = slide_n;
            if (slide_done) slide_seen++;
            if (ldiv_wr) begin
                if (ldiv_cnt < 8) ldiv_log[ldiv_cnt] = ldiv_half;
                ldiv_cnt++;
                if (!ldiv_half && arm_r) begin rest_gap = cyc - t_pl; arm_r = 0; end
                lw_v1 = lw_v0;
                lw_v0 = ldiv_half;
                lw_run++;
                ldiv_reg = ldiv_half;
            end else begin
                if (ldiv_rd) begin
                    rd_cnt++;
                    if (!(lw_run == 2 && lw_v0 == lw_v1)) ld_bad++;
                    t_rd = cyc;
                    if (lw_v0) arm_h = 1;
                end
                lw_run = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_log(input logic [3:0] cp, input logic [3:0] np);
        pl_cnt = 0; ldiv_cnt = 0; rd_cnt = 0; glitch_bad = 0; one_bad = 0;
        ld_bad = 0; half_gap = -1; rest_gap = -1; err_cyc = 0; busy_cyc = 0;
        byp_seen = 0; slide_seen = 0; lw_run = 0; arm_h = 0; arm_r = 0;
        byp_n_seen = '0; byp_m_seen = '0; slide_n_seen = '0;
        for (int i = 0; i < 8; i++) begin pl_log[i] = '0; ldiv_log[i] = 1'b0; end
        prev_code = cp;
        exp_new = np;
    endtask

    int acc_busy;

    task automatic run_seq(input logic [7:0] cm, input logic [7:0] nm,
                           input logic [9:0] nn, input logic [3:0] cp,
                           input logic [3:0] np, input bit al, input bit en,
                           input bit poke);
        int w;
        clear_log(cp, np);
        @(negedge clk);
        req_valid = 1'b1; cur_m = cm; new_m = nm; new_n = nn;
        cur_pl = cp; new_pl = np; allow_slide = al; pll_enabled = en;
        @(negedge clk);
        req_valid = 1'b0;
        acc_busy = busy;
        w = 0;
        while (busy && w < 5000) begin
            @(negedge clk);
            w++;
            if (poke && w == 3) begin
                req_valid = 1'b1; cur_pl = 4'd0; new_pl = 4'd0; new_m = 8'd9;
            end
            if (poke && w == 5) begin
                req_valid = 1'b0; cur_pl = cp; new_pl = np; new_m = nm;
            end
        end
        chk("R11 sequence completes", int'(busy), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 busy low", int'(busy), 0);
        chk("R1 err low", int'(err), 0);
        chk("R1 pl_wr low", int'(pl_wr), 0);
        chk("R1 ldiv_wr low", int'(ldiv_wr), 0);
        chk("R1 ldiv_rd low", int'(ldiv_rd), 0);
        chk("R1 bypass_req low", int'(bypass_req), 0);
        chk("R1 slide_req low", int'(slide_req), 0);
    endtask

    task automatic t_fast_common;
        run_seq(8'd1, 8'd1, 10'd150, 4'd3, 4'd2, 1, 1, 0);
        chk("R11 busy after accept", acc_busy, 1);
        chk("R2 single write count", pl_cnt, 1);
        chk("R2 single write code", int'(pl_log[0]), 2);
        chk("R3 shared bit", glitch_bad, 0);
        chk("R9 no divider write", ldiv_cnt, 0);
        chk("R7 fast no bypass", byp_seen, 0);
        chk("R10 slide handshake", slide_seen, 1);
        chk("R10 slide target", int'(slide_n_seen), 150);
    endtask

    task automatic t_fast_interim;
        run_seq(8'd2, 8'd2, 10'd120, 4'd4, 4'd3, 1, 1, 0);
        chk("R2 4to3 count", pl_cnt, 2);
        chk("R2 4to3 interim", int'(pl_log[0]), 5);
        chk("R2 4to3 target", int'(pl_log[1]), 3);
        chk("R3 4to3 shared", glitch_bad, 0);
        chk("R7 4to3 no bypass", byp_seen, 0);
        run_seq(8'd2, 8'd2, 10'd120, 4'd2, 4'd5, 1, 1, 0);
        chk("R2 2to5 interim", int'(pl_log[0]), 3);
        chk("R2 2to5 target", int'(pl_log[1]), 5);
        chk("R3 2to5 shared", glitch_bad, 0);
    endtask

    task automatic t_fast_one;
        run_seq(8'd3, 8'd3, 10'd210, 4'd1, 4'd2, 1, 1, 0);
        chk("R2 1to2 interim", int'(pl_log[0]), 3);
        chk("R2 1to2 target", int'(pl_log[1]), 2);
        chk("R3 1to2 shared", glitch_bad, 0);
        chk("R4 code1 under half", one_bad, 0);
        chk("R5 four divider writes", ldiv_cnt, 4);
        chk("R4 first divider value", int'(ldiv_log[0]), 1);
        chk("R5 second divider value", int'(ldiv_log[1]), 1);
        chk("R9 restore value", int'(ldiv_log[2]), 0);
        chk("R5 restore pair", int'(ldiv_log[3]), 0);
        chk("R5 read-backs", rd_cnt, 2);
        chk("R5 pair then read", ld_bad, 0);
        chk("R6 entry settle", half_gap, SETTLE + 1);
        chk("R6 exit settle", rest_gap, SETTLE + 1);
        run_seq(8'd3, 8'd3, 10'd210, 4'd2, 4'd1, 1, 1, 0);
        chk("R2 2to1 interim", int'(pl_log[0]), 3);
        chk("R2 2to1 target", int'(pl_log[1]), 1);
        chk("R4 2to1 half first", int'(ldiv_log[0]), 1);
        chk("R4 2to1 code1 under half", one_bad, 0);
    endtask

    task automatic t_restore_only;
        @(negedge clk);
        ldiv_reg = 1'b1;
        run_seq(8'd1, 8'd1, 10'd90, 4'd3, 4'd2, 1, 1, 0);
        chk("R9 restore writes", ldiv_cnt, 2);
        chk("R9 restore to 1:1", int'(ldiv_log[0]), 0);
        chk("R6 restore settle", rest_gap, SETTLE + 1);
        chk("R9 divider ends 1:1", int'(ldiv_reg), 0);
    endtask

    task automatic t_bypass;
        int b0;
        run_seq(8'd1, 8'd3, 10'd300, 4'd2, 4'd4, 1, 1, 1);
        chk("R8 bypass requested", byp_seen, 1);
        chk("R8 bypass m", int'(byp_m_seen), 3);
        chk("R8 bypass n exact", int'(byp_n_seen), 325);
        chk("R8 target write count", pl_cnt, 1);
        chk("R8 target write code", int'(pl_log[0]), 4);
        chk("R10 slide target", int'(slide_n_seen), 300);
        chk("R11 busy poke no err", err_cyc, 0);
        b0 = busy_cyc;
        repeat (20) @(negedge clk);
        chk("R11 poke started nothing", busy_cyc, b0);
        chk("R11 poke no extra write", pl_cnt, 1);
        run_seq(8'd2, 8'd1, 10'd200, 4'd4, 4'd2, 1, 1, 0);
        chk("R8 bypass n rounds up", int'(byp_n_seen), 109);
    endtask

    task automatic t_noslide;
        run_seq(8'd5, 8'd5, 10'd77, 4'd4, 4'd1, 0, 1, 0);
        chk("R7 no slide takes bypass", byp_seen, 1);
        chk("R8 bypass n is target", int'(byp_n_seen), 77);
        chk("R8 target code 1", int'(pl_log[0]), 1);
        chk("R4 half before bypass", int'(ldiv_log[0]), 1);
        chk("R4 code1 under half", one_bad, 0);
        chk("R6 entry settle to bypass", half_gap, SETTLE + 1);
    endtask

    task automatic t_disabled;
        run_seq(8'd4, 8'd4, 10'd180, 4'd3, 4'd6, 1, 0, 0);
        chk("R7 disabled takes bypass", byp_seen, 1);
        chk("R8 disabled floor n", int'(byp_n_seen), 434);
        chk("R3 bypass target shared", glitch_bad, 0);
    endtask

    task automatic t_illegal;
        run_seq(8'd1, 8'd1, 10'd50, 4'd3, 4'd0, 1, 1, 0);
        chk("R12 err pulse new 0", err_cyc, 1);
        chk("R12 not busy", acc_busy, 0);
        chk("R12 no busy cycles", busy_cyc, 0);
        chk("R12 no write", pl_cnt + ldiv_cnt + byp_seen, 0);
        run_seq(8'd1, 8'd1, 10'd50, 4'd0, 4'd2, 1, 1, 0);
        chk("R12 err pulse cur 0", err_cyc, 1);
        chk("R12 cur 0 no busy", busy_cyc, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast_common();
        t_fast_interim();
        t_fast_one();
        t_restore_only();
        t_bypass();
        t_noslide();
        t_disabled();
        t_illegal();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule